// File: doc/BRIEF.md
# MDIO Management Master with Bus Steering

This block is a management-interface master for Ethernet PHYs that software drives through a small 32-bit register bus. It owns a group of internal MDIO buses and a group of external MDIO buses. Software fills a packed parameter word and an address word, then writes an operation code to the control register. A frame engine shifts out one Clause 22 frame, or a Clause 45 address frame followed by a data frame. For a read, the engine releases the data line during turnaround and collects sixteen bits from the PHY. Software polls a done flag and, after a read, fetches the captured value from the read-data register.

Each group has its own rate register. The register sets the MDC period as a multiple of the core clock, so one clock can serve slow and fast PHYs. Only the bus chosen at start toggles its MDC. All other buses keep MDC low and leave MDIO undriven. The external group is driven only after software claims it through an ownership bit in the scan-control register.

Top module: `mdio_bus_master`

## Requirements
- R1: After reset, the status register (0x24C) reads 0 and the read-data register (0x240) reads 0. Both rate registers (0x000 external, 0x004 internal) read 0x0001_0002. Every MDC output is low and every MDIO enable is low.
- R2: The following registers read back what was written:
  - the parameter register (0x23C), all 32 bits;
  - the address register (0x244), bits 20:0, with the upper bits reading 0;
  - scan control (0x008), bit 28 only.
- R3: A Clause 22 write (control value 1 with parameter bit 21 clear) sends 64 MDC cycles, all with MDIO driven and most significant bit first:
  - 32 ones;
  - start 01 and opcode 01;
  - the PHY address (parameter bits 20:16);
  - the register address (address bits 4:0);
  - turnaround 10;
  - the data (parameter bits 15:0).
- R4: A Clause 22 read (control value 2) sends the same layout with opcode 10. It releases MDIO for the last 18 cycles, which are turnaround plus data. It samples MDIO on each rising MDC edge of the data phase, most significant bit first. Afterwards, register 0x240 bits 15:0 hold the sampled word.
- R5: With parameter bit 21 set, the engine sends two frames in a row.
  - The first is an address frame: 32 ones, start 00, opcode 00, the port address (parameter bits 20:16), the device address (address bits 20:16), turnaround 10, and the register number (address bits 15:0).
  - The second frame uses start 00 and opcode 01 for a write or 11 for a read, with the same port and device fields. A read releases MDIO for its last 18 cycles.
- R6: Status bit 0 becomes 1 when the last frame ends. It stays 1, across any number of reads, until control is written with 0. It then reads 0.
- R7: A control write of 1, 2 or 3 while a transaction is running has no effect. The frames sent and the MDC cycle count stay those of the original operation.
- R8: Parameter bit 25 set selects internal bus number bits 24:22, and bit 25 clear selects external bus number bits 24:22. Only that bus toggles MDC or enables MDIO. A bus number beyond the group size toggles nothing, and the transaction still completes.
- R9: The MDC period in core cycles is P = divisor × (dividend + 1), with a minimum of 2. The divisor is in bits 7:0 and the dividend in bits 19:16 of the group's rate register. MDC is low for floor(P/2) cycles and high for the rest.
- R10: While scan-control bit 28 is 0, external MDC stays low and external MDIO stays released. A transaction aimed at the external group still sets done.
- R11: Writing 0 to control during a transaction aborts it on the next clock edge. All MDC outputs go low and all enables go low, and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| int_mdc_o | output | NUM_INT | MDC per internal bus |
| int_mdio_o | output | NUM_INT | MDIO drive value per internal bus |
| int_mdio_oe_o | output | NUM_INT | MDIO drive enable per internal bus |
| int_mdio_i | input | NUM_INT | MDIO input per internal bus |
| ext_mdc_o | output | NUM_EXT | MDC per external bus |
| ext_mdio_o | output | NUM_EXT | MDIO drive value per external bus |
| ext_mdio_oe_o | output | NUM_EXT | MDIO drive enable per external bus |
| ext_mdio_i | input | NUM_EXT | MDIO input per external bus |

## Verification
The assertions take for granted that the rate registers are not rewritten in a way that matters mid-frame. That holds because the period is latched at start. They also assume software changes parameter and address only while no transaction runs. The bench keeps to this: it programs those registers only between the done flag and the next start, and it sends a control write during a transaction only in the ignored-start and abort cases. The PHY responder in the bench drives MDIO only when the master has released it, so the bus is never driven from both ends.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned ID_W   = 3;

  localparam logic [ADDR_W-1:0] OFF_RATE_EXT = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_RATE_INT = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_SCAN     = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_PARAM    = 12'h23C;
  localparam logic [ADDR_W-1:0] OFF_RDATA    = 12'h240;
  localparam logic [ADDR_W-1:0] OFF_ADDR     = 12'h244;
  localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'h248;
  localparam logic [ADDR_W-1:0] OFF_STAT     = 12'h24C;

  localparam int unsigned OWN_BIT   = 28;
  localparam int unsigned DVD_LSB   = 16;
  localparam int unsigned ADDR_KEEP = 21;
  localparam int unsigned FRAME_LEN = 64;

  localparam logic [1:0] OPC_IDLE  = 2'd0;
  localparam logic [1:0] OPC_WRITE = 2'd1;
  localparam logic [1:0] OPC_READ  = 2'd2;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_BUSY = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int unsigned DIVW = 8,
  parameter int unsigned DVDW = 4,
  parameter logic [DIVW-1:0] DIV_RST = 2,
  parameter logic [DVDW-1:0] DVD_RST = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [15:0]          rd_value_i,
  input  logic                 done_i,
  output logic [25:0]          param_o,
  output logic [ADDR_KEEP-1:0] maddr_o,
  output logic [DIVW-1:0]      div_int_o,
  output logic [DVDW-1:0]      dvd_int_o,
  output logic [DIVW-1:0]      div_ext_o,
  output logic [DVDW-1:0]      dvd_ext_o,
  output logic                 ext_own_o,
  output logic                 start_o,
  output logic                 start_rd_o,
  output logic                 clr_o
);
  logic [REG_W-1:0]     param_q;
  logic [ADDR_KEEP-1:0] maddr_q;
  logic [DIVW-1:0]      div_int_q, div_ext_q;
  logic [DVDW-1:0]      dvd_int_q, dvd_ext_q;
  logic                 own_q;
  logic [1:0]           ctrl_q;

  logic en_param, en_addr, en_rint, en_rext, en_scan, en_ctrl;

  always_comb begin
    en_param = we_i && (addr_i == OFF_PARAM);
    en_addr  = we_i && (addr_i == OFF_ADDR);
    en_rint  = we_i && (addr_i == OFF_RATE_INT);
    en_rext  = we_i && (addr_i == OFF_RATE_EXT);
    en_scan  = we_i && (addr_i == OFF_SCAN);
    en_ctrl  = we_i && (addr_i == OFF_CTRL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      param_q   <= '0;
      maddr_q   <= '0;
      div_int_q <= DIV_RST;
      dvd_int_q <= DVD_RST;
      div_ext_q <= DIV_RST;
      dvd_ext_q <= DVD_RST;
      own_q     <= 1'b0;
      ctrl_q    <= OPC_IDLE;
    end else begin
      if (en_param) param_q <= wdata_i;
      if (en_addr)  maddr_q <= wdata_i[ADDR_KEEP-1:0];
      if (en_rint) begin
        div_int_q <= wdata_i[DIVW-1:0];
        dvd_int_q <= wdata_i[DVD_LSB +: DVDW];
      end
      if (en_rext) begin
        div_ext_q <= wdata_i[DIVW-1:0];
        dvd_ext_q <= wdata_i[DVD_LSB +: DVDW];
      end
      if (en_scan)  own_q  <= wdata_i[OWN_BIT];
      if (en_ctrl)  ctrl_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_RATE_EXT: begin
        rdata_o[DIVW-1:0]       = div_ext_q;
        rdata_o[DVD_LSB +: DVDW] = dvd_ext_q;
      end
      OFF_RATE_INT: begin
        rdata_o[DIVW-1:0]       = div_int_q;
        rdata_o[DVD_LSB +: DVDW] = dvd_int_q;
      end
      OFF_SCAN:  rdata_o[OWN_BIT] = own_q;
      OFF_PARAM: rdata_o = param_q;
      OFF_RDATA: rdata_o[15:0] = rd_value_i;
      OFF_ADDR:  rdata_o[ADDR_KEEP-1:0] = maddr_q;
      OFF_CTRL:  rdata_o[1:0] = ctrl_q;
      OFF_STAT:  rdata_o[0] = done_i;
      default:   rdata_o = '0;
    endcase
  end

  assign param_o    = param_q[25:0];
  assign maddr_o    = maddr_q;
  assign div_int_o  = div_int_q;
  assign dvd_int_o  = dvd_int_q;
  assign div_ext_o  = div_ext_q;
  assign dvd_ext_o  = dvd_ext_q;
  assign ext_own_o  = own_q;
  assign start_o    = en_ctrl && ((wdata_i[1:0] == OPC_WRITE) || (wdata_i[1:0] == OPC_READ));
  assign start_rd_o = (wdata_i[1:0] == OPC_READ);
  assign clr_o      = en_ctrl && (wdata_i[1:0] == OPC_IDLE);
endmodule

// File: rtl/mdm_clkdiv.sv
module mdm_clkdiv #(
  parameter int unsigned PW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          rise_tick_o,
  output logic          end_tick_o,
  output logic          mdc_o
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] half;

  assign half = period_i >> 1;

  always_comb begin
    if (!run_i || (cnt_q == period_i - PW'(1))) cnt_d = '0;
    else                                          cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign rise_tick_o = run_i && (cnt_q == half - PW'(1));
  assign end_tick_o  = run_i && (cnt_q == period_i - PW'(1));
  assign mdc_o       = run_i && (cnt_q >= half);

  // R9
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < period_i));
endmodule

// File: rtl/mdm_frame.sv
module mdm_frame
  import mdm_pkg::*;
#(
  parameter int unsigned PW = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 start_rd_i,
  input  logic                 clr_i,
  input  logic [25:0]          param_i,
  input  logic [ADDR_KEEP-1:0] maddr_i,
  input  logic [PW-1:0]        period_i,
  input  logic                 rise_tick_i,
  input  logic                 end_tick_i,
  input  logic                 mdio_in_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 bit_o,
  output logic                 oe_o,
  output logic                 sel_int_o,
  output logic [ID_W-1:0]      sel_id_o,
  output logic [PW-1:0]        period_o,
  output logic [15:0]          rd_data_o
);
  eng_state_e           state_q, state_d;
  logic [5:0]           bit_q, bit_d;
  logic                 second_q, second_d;
  logic [15:0]          shreg_q, shreg_d;
  logic [15:0]          rdat_q, rdat_d;
  logic                 lat_rd, lat_c45, lat_int;
  logic [4:0]           lat_phy;
  logic [15:0]          lat_data;
  logic [ADDR_KEEP-1:0] lat_addr;
  logic [ID_W-1:0]      lat_id;
  logic [PW-1:0]        lat_period;

  logic        accept, last_frame, rd_frame, frame_end;
  logic [1:0]  f_st, f_op;
  logic [4:0]  f_dev;
  logic [15:0] f_dat;
  logic [31:0] word;

  assign accept     = start_i && !clr_i && (state_q != ENG_BUSY);
  assign last_frame = !lat_c45 || second_q;
  assign rd_frame   = lat_rd && last_frame;
  assign frame_end  = end_tick_i && (bit_q == 6'(FRAME_LEN - 1));

  always_comb begin
    if (!lat_c45) begin
      f_st  = 2'b01;
      f_op  = lat_rd ? 2'b10 : 2'b01;
      f_dev = lat_addr[4:0];
      f_dat = lat_data;
    end else if (!second_q) begin
      f_st  = 2'b00;
      f_op  = 2'b00;
      f_dev = lat_addr[20:16];
      f_dat = lat_addr[15:0];
    end else begin
      f_st  = 2'b00;
      f_op  = lat_rd ? 2'b11 : 2'b01;
      f_dev = lat_addr[20:16];
      f_dat = lat_data;
    end
    word = {f_st, f_op, lat_phy, f_dev, 2'b10, f_dat};
  end

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    second_d = second_q;
    shreg_d  = shreg_q;
    rdat_d   = rdat_q;
    if (clr_i) begin
      state_d = ENG_IDLE;
    end else if (accept) begin
      state_d  = ENG_BUSY;
      bit_d    = '0;
      second_d = 1'b0;
      shreg_d  = '0;
    end else if (state_q == ENG_BUSY) begin
      if (rise_tick_i && rd_frame && (bit_q >= 6'd48))
        shreg_d = {shreg_q[14:0], mdio_in_i};
      if (end_tick_i) begin
        bit_d = bit_q + 6'd1;
        if (frame_end) begin
          if (last_frame) begin
            state_d = ENG_DONE;
            if (lat_rd) rdat_d = shreg_q;
          end else begin
            second_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ENG_IDLE;
      bit_q    <= '0;
      second_q <= 1'b0;
      shreg_q  <= '0;
      rdat_q   <= '0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      second_q <= second_d;
      shreg_q  <= shreg_d;
      rdat_q   <= rdat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_rd     <= 1'b0;
      lat_c45    <= 1'b0;
      lat_int    <= 1'b0;
      lat_phy    <= '0;
      lat_data   <= '0;
      lat_addr   <= '0;
      lat_id     <= '0;
      lat_period <= PW'(2);
    end else if (accept) begin
      lat_rd     <= start_rd_i;
      lat_c45    <= param_i[21];
      lat_int    <= param_i[25];
      lat_phy    <= param_i[20:16];
      lat_data   <= param_i[15:0];
      lat_addr   <= maddr_i;
      lat_id     <= param_i[24:22];
      lat_period <= period_i;
    end
  end

  assign busy_o    = (state_q == ENG_BUSY);
  assign done_o    = (state_q == ENG_DONE);
  assign bit_o     = bit_q[5] ? word[~bit_q[4:0]] : 1'b1;
  assign oe_o      = busy_o && !(rd_frame && (bit_q >= 6'd46));
  assign sel_int_o = lat_int;
  assign sel_id_o  = lat_id;
  assign period_o  = lat_period;
  assign rd_data_o = rdat_q;

  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_DONE && !clr_i && !start_i) |=> (state_q == ENG_DONE));

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_BUSY && start_i && !clr_i) |=>
      ((state_q != ENG_IDLE) && $stable(lat_rd) && $stable(lat_phy) && $stable(lat_addr)));
endmodule

// File: rtl/mdm_steer.sv
module mdm_steer
  import mdm_pkg::*;
#(
  parameter int unsigned NUM_INT = 2,
  parameter int unsigned NUM_EXT = 2
) (
  input  logic               mdc_i,
  input  logic               bit_i,
  input  logic               oe_i,
  input  logic               sel_int_i,
  input  logic [ID_W-1:0]    sel_id_i,
  input  logic               ext_own_i,
  output logic [NUM_INT-1:0] int_mdc_o,
  output logic [NUM_INT-1:0] int_mdio_o,
  output logic [NUM_INT-1:0] int_oe_o,
  input  logic [NUM_INT-1:0] int_mdio_i,
  output logic [NUM_EXT-1:0] ext_mdc_o,
  output logic [NUM_EXT-1:0] ext_mdio_o,
  output logic [NUM_EXT-1:0] ext_oe_o,
  input  logic [NUM_EXT-1:0] ext_mdio_i,
  output logic               mdio_in_o
);
  logic [NUM_INT-1:0] int_hit;
  logic [NUM_EXT-1:0] ext_hit;

  for (genvar gi = 0; gi < NUM_INT; gi++) begin : g_int
    assign int_hit[gi]    = sel_int_i && (sel_id_i == ID_W'(gi));
    assign int_mdc_o[gi]  = mdc_i && int_hit[gi];
    assign int_mdio_o[gi] = bit_i && int_hit[gi];
    assign int_oe_o[gi]   = oe_i && int_hit[gi];
  end

  for (genvar ge = 0; ge < NUM_EXT; ge++) begin : g_ext
    assign ext_hit[ge]    = !sel_int_i && ext_own_i && (sel_id_i == ID_W'(ge));
    assign ext_mdc_o[ge]  = mdc_i && ext_hit[ge];
    assign ext_mdio_o[ge] = bit_i && ext_hit[ge];
    assign ext_oe_o[ge]   = oe_i && ext_hit[ge];
  end

  always_comb begin
    mdio_in_o = 1'b1;
    for (int i = 0; i < NUM_INT; i++) if (int_hit[i]) mdio_in_o = int_mdio_i[i];
    for (int j = 0; j < NUM_EXT; j++) if (ext_hit[j]) mdio_in_o = ext_mdio_i[j];
  end
endmodule

// File: rtl/mdio_bus_master.sv
module mdio_bus_master
  import mdm_pkg::*;
#(
  parameter int unsigned NUM_INT = 2,
  parameter int unsigned NUM_EXT = 2,
  parameter int unsigned DIVW    = 8,
  parameter int unsigned DVDW    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [11:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [NUM_INT-1:0] int_mdc_o,
  output logic [NUM_INT-1:0] int_mdio_o,
  output logic [NUM_INT-1:0] int_mdio_oe_o,
  input  logic [NUM_INT-1:0] int_mdio_i,
  output logic [NUM_EXT-1:0] ext_mdc_o,
  output logic [NUM_EXT-1:0] ext_mdio_o,
  output logic [NUM_EXT-1:0] ext_mdio_oe_o,
  input  logic [NUM_EXT-1:0] ext_mdio_i
);
  localparam int unsigned PW = DIVW + DVDW + 1;

  logic rst_meta, rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic [25:0]          param;
  logic [ADDR_KEEP-1:0] maddr;
  logic [DIVW-1:0]      div_int, div_ext;
  logic [DVDW-1:0]      dvd_int, dvd_ext;
  logic                 ext_own, start, start_rd, clr;
  logic                 busy, done, bit_v, oe_v, sel_int, mdc_v, mdio_in;
  logic                 rise_tick, end_tick;
  logic [ID_W-1:0]      sel_id;
  logic [PW-1:0]        p_int_raw, p_ext_raw, p_int, p_ext, p_start, p_run;
  logic [15:0]          rd_value;

  mdm_regs #(.DIVW(DIVW), .DVDW(DVDW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_s), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .rd_value_i(rd_value),
    .done_i(done), .param_o(param), .maddr_o(maddr),
    .div_int_o(div_int), .dvd_int_o(dvd_int), .div_ext_o(div_ext), .dvd_ext_o(dvd_ext),
    .ext_own_o(ext_own), .start_o(start), .start_rd_o(start_rd), .clr_o(clr)
  );

  always_comb begin
    p_int_raw = PW'(div_int) * (PW'(dvd_int) + PW'(1));
    p_ext_raw = PW'(div_ext) * (PW'(dvd_ext) + PW'(1));
    p_int     = (p_int_raw < PW'(2)) ? PW'(2) : p_int_raw;
    p_ext     = (p_ext_raw < PW'(2)) ? PW'(2) : p_ext_raw;
    p_start   = param[25] ? p_int : p_ext;
  end

  mdm_frame #(.PW(PW)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_n_s), .start_i(start), .start_rd_i(start_rd),
    .clr_i(clr), .param_i(param), .maddr_i(maddr), .period_i(p_start),
    .rise_tick_i(rise_tick), .end_tick_i(end_tick), .mdio_in_i(mdio_in),
    .busy_o(busy), .done_o(done), .bit_o(bit_v), .oe_o(oe_v),
    .sel_int_o(sel_int), .sel_id_o(sel_id), .period_o(p_run), .rd_data_o(rd_value)
  );

  mdm_clkdiv #(.PW(PW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_n_s), .run_i(busy), .period_i(p_run),
    .rise_tick_o(rise_tick), .end_tick_o(end_tick), .mdc_o(mdc_v)
  );

  mdm_steer #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT)) u_steer (
    .mdc_i(mdc_v), .bit_i(bit_v), .oe_i(oe_v), .sel_int_i(sel_int),
    .sel_id_i(sel_id), .ext_own_i(ext_own),
    .int_mdc_o(int_mdc_o), .int_mdio_o(int_mdio_o), .int_oe_o(int_mdio_oe_o),
    .int_mdio_i(int_mdio_i),
    .ext_mdc_o(ext_mdc_o), .ext_mdio_o(ext_mdio_o), .ext_oe_o(ext_mdio_oe_o),
    .ext_mdio_i(ext_mdio_i), .mdio_in_o(mdio_in)
  );

  // R1
  idle_pins_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !busy |-> (int_mdc_o == '0 && ext_mdc_o == '0 &&
               int_mdio_oe_o == '0 && ext_mdio_oe_o == '0));

  // R10
  ext_hands_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !ext_own |-> (ext_mdc_o == '0 && ext_mdio_oe_o == '0));

  // R8
  one_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $onehot0({ext_mdio_oe_o, int_mdio_oe_o}));
endmodule

// File: tb/mdio_bus_master_bench.sv
module mdio_bus_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 2;
  localparam int NE = 2;
  localparam logic [11:0] A_REXT = 12'h000, A_RINT = 12'h004, A_SCAN = 12'h008,
                          A_PARAM = 12'h23C, A_RDAT = 12'h240, A_ADDR = 12'h244,
                          A_CTRL = 12'h248, A_STAT = 12'h24C;

  logic clk = 1'b0;
  logic rst_n;
  logic we;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [NI-1:0] int_mdc, int_o, int_oe, int_i;
  logic [NE-1:0] ext_mdc, ext_o, ext_oe, ext_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_bus_master u_mdio_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .int_mdc_o(int_mdc), .int_mdio_o(int_o), .int_mdio_oe_o(int_oe), .int_mdio_i(int_i),
    .ext_mdc_o(ext_mdc), .ext_mdio_o(ext_o), .ext_mdio_oe_o(ext_oe), .ext_mdio_i(ext_i)
  );

  // PHY responder and frame capture
  logic        resp = 1'b1;
  logic [15:0] resp_word = '0;
  logic [3:0]  mask_exp = '0;
  logic [63:0] cap_v [2];
  logic [63:0] cap_oe [2];
  int   rcount = 0;
  int   bad_mask = 0;
  time  t_r0, t_r1, t_f0;
  wire  mdc_any = |{ext_mdc, int_mdc};

  assign int_i = {NI{resp}};
  assign ext_i = {NE{resp}};

  always @(posedge mdc_any) begin
    int k, fi;
    k  = rcount % 64;
    fi = rcount / 64;
    if ({ext_mdc, int_mdc} != mask_exp) bad_mask++;
    if (({ext_oe, int_oe} & ~mask_exp) != 0) bad_mask++;
    if (fi < 2) begin
      cap_oe[fi][63-k] = |({ext_oe, int_oe} & mask_exp);
      cap_v[fi][63-k]  = |({ext_o, int_o} & {ext_oe, int_oe} & mask_exp);
    end
    if (rcount == 0) t_r0 = $time;
    if (rcount == 1) t_r1 = $time;
    rcount++;
  end

  always @(negedge mdc_any) begin
    int idx;
    if (rcount == 1) t_f0 = $time;
    idx = rcount % 64;
    resp = (idx >= 48) ? resp_word[63-idx] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [63:0] frame_exp(bit c45, bit second, bit rd,
                                            int phy, int regn, int dev, int data);
    logic [1:0] st, op; logic [4:0] f2; logic [15:0] d;
    if (!c45) begin st = 2'b01; op = rd ? 2'b10 : 2'b01; f2 = regn[4:0]; d = data[15:0]; end
    else if (!second) begin st = 2'b00; op = 2'b00; f2 = dev[4:0]; d = regn[15:0]; end
    else begin st = 2'b00; op = rd ? 2'b11 : 2'b01; f2 = dev[4:0]; d = data[15:0]; end
    return {32'hFFFF_FFFF, st, op, phy[4:0], f2, 2'b10, d};
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit got = 0;
    for (int n = 0; n < 6000 && !got; n++) begin
      reg_read(A_STAT, v);
      got = v[0];
    end
    chk(got, req, {63'd0, got}, 64'd1);
  endtask

  task automatic run_txn(input bit is_int, input int id, input bit c45, input bit rd,
                         input int phy, input int regn, input int dev, input int data,
                         input int rw, input bit active, input bit poke, input string req);
    logic [31:0] v;
    int nf;
    nf = c45 ? 2 : 1;
    mask_exp  = active ? (is_int ? 4'(1 << id) : 4'(1 << (NI + id))) : 4'd0;
    resp_word = rw[15:0];
    rcount = 0; bad_mask = 0;
    cap_v[0] = '0; cap_v[1] = '0; cap_oe[0] = '0; cap_oe[1] = '0;
    reg_write(A_PARAM, (data & 32'hFFFF) | (phy << 16) | (32'(c45) << 21) |
                       (id << 22) | (32'(is_int) << 25));
    reg_write(A_ADDR, (dev << 16) | (regn & 32'hFFFF));
    reg_write(A_CTRL, rd ? 32'd2 : 32'd1);
    if (poke) begin
      repeat (40) @(negedge clk);
      reg_write(A_CTRL, rd ? 32'd1 : 32'd2);  // R7: ignored
      reg_write(A_CTRL, 32'd3);
    end
    wait_done(req);
    chk(rcount == (active ? 64 * nf : 0), req, 64'(rcount), 64'(active ? 64 * nf : 0));
    chk(bad_mask == 0, {req, " R8 bus isolation"}, 64'(bad_mask), 64'd0);
    if (active) begin
      for (int f = 0; f < nf; f++) begin
        logic [63:0] ev, eo;
        ev = frame_exp(c45, f == 1, rd, phy, regn, dev, data);
        eo = (rd && f == nf - 1) ? ~64'h3FFFF : ~64'd0;
        chk(cap_oe[f] == eo, {req, " drive mask"}, cap_oe[f], eo);
        chk(((cap_v[f] ^ ev) & eo) == 0, {req, " frame bits"}, cap_v[f], ev);
      end
      if (rd) begin
        reg_read(A_RDAT, v);
        chk(v == 32'(rw[15:0]), {req, " R4 read data"}, 64'(v), 64'(rw[15:0]));
      end
    end
    reg_write(A_CTRL, 32'd0);
    reg_read(A_STAT, v);
    chk(v == 0, {req, " R6 done cleared"}, 64'(v), 64'd0);
  endtask

  initial begin
    logic [31:0] v;
    we = 0; addr = '0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    reg_read(A_STAT, v);  chk(v == 0, "R1 status", 64'(v), 0);
    reg_read(A_RDAT, v);  chk(v == 0, "R1 rdata", 64'(v), 0);
    reg_read(A_RINT, v);  chk(v == 32'h0001_0002, "R1 rate int", 64'(v), 64'h10002);
    reg_read(A_REXT, v);  chk(v == 32'h0001_0002, "R1 rate ext", 64'(v), 64'h10002);
    chk({ext_mdc, int_mdc, ext_oe, int_oe} == 0, "R1 pins", 64'({ext_mdc, int_mdc, ext_oe, int_oe}), 0);

    // R2 readback
    reg_write(A_PARAM, 32'hE5A3_5C71); reg_read(A_PARAM, v);
    chk(v == 32'hE5A3_5C71, "R2 param", 64'(v), 64'hE5A35C71);
    reg_write(A_ADDR, 32'hFFFF_FFFF); reg_read(A_ADDR, v);
    chk(v == 32'h001F_FFFF, "R2 addr", 64'(v), 64'h1FFFFF);
    reg_write(A_SCAN, 32'hFFFF_FFFF); reg_read(A_SCAN, v);
    chk(v == 32'h1000_0000, "R2 scan", 64'(v), 64'h10000000);

    // R3 / R4 sweep over every PHY address and all four buses
    for (int p = 0; p < 32; p++) begin
      int b;
      b = p % 4;
      run_txn(b < 2, b % 2, 0, 0, p, 31 - p, 0, (p * 16'h0841) ^ 16'hA5C3, 0, 1, 0, "R3 c22 write");
      run_txn(b >= 2, b % 2, 0, 1, p, p ^ 5'h15, 0, 0,
              ((p << 11) | ((~p & 31) << 3) | (p & 7)) ^ 16'h6A5A, 1, 0, "R4 c22 read");
    end

    // R5 Clause 45
    run_txn(1, 0, 1, 0, 5'h03, 16'hBEEF, 5'h1E, 16'h1234, 0, 1, 0, "R5 c45 write");
    run_txn(1, 1, 1, 1, 5'h1C, 16'h0001, 5'h07, 0, 16'hC3A5, 1, 0, "R5 c45 read");
    run_txn(0, 1, 1, 1, 5'h11, 16'h8000, 5'h01, 0, 16'h0F0F, 1, 0, "R5 c45 read ext");

    // R7 start requests during a transaction
    run_txn(1, 0, 0, 0, 5'h0A, 5'h0B, 0, 16'h5555, 0, 1, 1, "R7 c22 write poked");
    run_txn(0, 0, 0, 1, 5'h09, 5'h02, 0, 0, 16'h9669, 1, 1, "R7 c22 read poked");

    // R8 out-of-range bus number
    run_txn(1, 3, 0, 0, 5'h01, 5'h01, 0, 16'h1111, 0, 0, 0, "R8 absent bus");

    // R6 done holds across reads
    reg_write(A_PARAM, 32'h0201_0042);
    reg_write(A_CTRL, 32'd1);
    wait_done("R6 done set");
    repeat (25) @(negedge clk);
    reg_read(A_STAT, v); chk(v == 1, "R6 done holds", 64'(v), 1);
    reg_read(A_STAT, v); chk(v == 1, "R6 done holds again", 64'(v), 1);
    reg_write(A_CTRL, 32'd0);
    reg_read(A_STAT, v); chk(v == 0, "R6 cleared", 64'(v), 0);

    // R9 MDC period and duty
    reg_write(A_RINT, 32'h0001_0003);
    run_txn(1, 0, 0, 0, 1, 2, 0, 16'h00FF, 0, 1, 0, "R9 p6");
    chk(t_r1 - t_r0 == 6 * CLK_PERIOD, "R9 period p6", 64'(t_r1 - t_r0), 64'(6 * CLK_PERIOD));
    chk(t_f0 - t_r0 == 3 * CLK_PERIOD, "R9 high p6", 64'(t_f0 - t_r0), 64'(3 * CLK_PERIOD));
    reg_write(A_REXT, 32'h0000_0005);
    run_txn(0, 1, 0, 1, 3, 4, 0, 0, 16'hA001, 1, 0, "R9 p5");
    chk(t_r1 - t_r0 == 5 * CLK_PERIOD, "R9 period p5", 64'(t_r1 - t_r0), 64'(5 * CLK_PERIOD));
    chk(t_f0 - t_r0 == 3 * CLK_PERIOD, "R9 high p5", 64'(t_f0 - t_r0), 64'(3 * CLK_PERIOD));
    reg_write(A_RINT, 32'h0000_0001);
    run_txn(1, 1, 0, 0, 7, 8, 0, 16'h7E7E, 0, 1, 0, "R9 clamp");
    chk(t_r1 - t_r0 == 2 * CLK_PERIOD, "R9 period clamp", 64'(t_r1 - t_r0), 64'(2 * CLK_PERIOD));
    chk(t_f0 - t_r0 == 1 * CLK_PERIOD, "R9 high clamp", 64'(t_f0 - t_r0), 64'(CLK_PERIOD));

    // R10 external group not owned
    reg_write(A_SCAN, 32'h0);
    run_txn(0, 0, 0, 0, 2, 3, 0, 16'hFFFF, 0, 0, 0, "R10 ext unowned");
    run_txn(0, 1, 1, 1, 2, 3, 4, 0, 16'h1234, 0, 0, "R10 ext unowned c45");
    reg_write(A_SCAN, 32'h1000_0000);

    // R11 abort
    mask_exp = 4'b0001; rcount = 0;
    reg_write(A_PARAM, 32'h0200_1357);
    reg_write(A_CTRL, 32'd1);
    repeat (40) @(negedge clk);
    reg_write(A_CTRL, 32'd0);
    chk({ext_mdc, int_mdc, ext_oe, int_oe} == 0, "R11 pins idle",
        64'({ext_mdc, int_mdc, ext_oe, int_oe}), 0);
    begin
      int rc;
      rc = rcount;
      repeat (300) @(negedge clk);
      reg_read(A_STAT, v); chk(v == 0, "R11 no done", 64'(v), 0);
      chk(rcount == rc, "R11 no more MDC", 64'(rcount), 64'(rc));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule